// File: doc/BRIEF.md
# Double-Buffered DAC Bus Front End with Readback

This block is the digital control front end of a parallel-bus digital-to-analog converter. A host reaches it over a 16-bit data bus with active-low chip select, a read/not-write line, an active-low load strobe and an active-low clear strobe. The host writes a word into an input latch and can read that word back. A separate DAC latch holds the code that actually drives the converter, so several converters can be loaded first and then updated together by one shared load strobe.

All strobes and the data bus are sampled on the system clock through a parameterised synchronizer chain. The tri-state bus is modelled as a data output with an output enable. Clear forces the DAC latch to zero or to midscale, and the read/not-write line picks which. A hold output tells the analog output stage to freeze its last voltage for a fixed number of clock cycles after each falling edge of the load strobe. This hides the switching glitch while the converter settles to the new code.

Top module: `dacbus_ctl`

## Requirements
- R1: After reset the output enable is low, the DAC code is 0x0000, the hold output is low, and a readback returns 0x0000.
- R2: While chip select is high, the output enable is low and the input latch keeps its value, whatever the read/not-write, data and other strobes do.
- R3: With chip select low and read/not-write low, the sampled bus word is stored in the input latch and the bus is not driven.
- R4: With chip select low and read/not-write high, the output enable is high and the bus output carries the input latch contents.
- R5: While load is low and clear is high, the DAC latch takes the input latch contents, whatever chip select does; while both are high, the DAC latch keeps its value even across writes.
- R6: With load held low, the DAC code follows each new written word.
- R7: While clear is low, the DAC latch becomes 0x0000 if read/not-write is low and 0x8000 (only the top bit set) if it is high, whatever chip select does.
- R8: Clear does not change the input latch; a readback after a clear returns the last written word.
- R9: When clear and load are both low, clear decides the DAC latch.
- R10: A falling edge of the sampled load strobe raises the hold output for exactly HOLD_CYCLES clock cycles; a load held low with no new edge raises no further hold.
- R11: A new falling edge of load during a hold restarts the hold count from HOLD_CYCLES.
- R12: A change on any input pin reaches the outputs on exactly the (SYNC_STAGES+1)-th rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Chip select, active low |
| rd_wrn | input | 1 | High selects read, low selects write; also picks the clear value |
| load_n | input | 1 | Load strobe, active low, level sensitive |
| clear_n | input | 1 | Clear strobe, active low |
| bus_in | input | DW (16) | Data bus as seen by the block |
| bus_out | output | DW (16) | Readback word placed on the bus |
| bus_oe | output | 1 | Output enable for the bus drivers |
| dac_code | output | DW (16) | DAC latch contents fed to the converter |
| hold | output | 1 | High while the output stage must hold its voltage |

## Verification
The bench goes after clear-versus-load priority. A design that lets load win would put the input latch word on the converter while clear is low, rather than 0x0000 or 0x8000. Clear is also checked against the input latch, because a design that cleared both latches would return zero on the next readback. Writes with chip select high and loads with chip select high are mixed in to catch decoding that gates load or write wrongly. The hold output is counted cycle by cycle over a single edge, over a long low level, and over a retriggered edge. A timer that is off by one, one that re-arms on a level, or one that ignores a new edge while busy each gives a different count.

// File: rtl/dacbus_pkg.sv
`timescale 1ns/1ps
package dacbus_pkg;

   // Sampled control strobes, packed so they travel with the data word
   typedef struct packed {
      logic sel_n;
      logic rd_wrn;
      logic load_n;
      logic clear_n;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   // Inactive value: nothing selected, read direction, no strobes
   localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, rd_wrn: 1'b1, load_n: 1'b1, clear_n: 1'b1};

   function automatic logic [63:0] midscale(input int width);
      logic [63:0] v;
      v = '0;
      v[width-1] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/dacbus_sampler.sv
`timescale 1ns/1ps
module dacbus_sampler #(
   parameter int           W      = 20,
   parameter int           STAGES = 2,
   parameter logic [W-1:0] RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   initial assert (STAGES >= 0 && STAGES <= 8)
      else $error("dacbus_sampler: STAGES out of range");

   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stg[g] <= RST;
               end else if (g == 0) begin
                  stg[g] <= din;
               end else begin
                  stg[g] <= stg[(g == 0) ? 0 : g-1];
               end
            end
         end
         assign dout = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dacbus_inlatch.sv
`timescale 1ns/1ps
module dacbus_inlatch #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          rd_wrn,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] latch_q,
   output logic [DW-1:0] bus_out,
   output logic          bus_oe
);

   initial assert (DW >= 2) else $error("dacbus_inlatch: DW too small");

   logic wr_en;
   logic rd_en;

   assign wr_en = !sel_n && !rd_wrn;
   assign rd_en = !sel_n &&  rd_wrn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (wr_en) begin
         latch_q <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_out <= '0;
         bus_oe  <= 1'b0;
      end else begin
         bus_out <= latch_q;
         bus_oe  <= rd_en;
      end
   end

   AST_RELEASE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> !bus_oe); // R2
   AST_KEEP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> $stable(latch_q)); // R2
   AST_STORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !rd_wrn) |=> (latch_q == $past(din)) && !bus_oe); // R3
   AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && rd_wrn) |=> bus_oe && (bus_out == $past(latch_q))); // R4

endmodule

// File: rtl/dacbus_daclatch.sv
`timescale 1ns/1ps
module dacbus_daclatch
   import dacbus_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_wrn,
   input  logic          load_n,
   input  logic          clear_n,
   input  logic [DW-1:0] src,
   output logic [DW-1:0] dac_q
);

   localparam logic [63:0]   MID64 = midscale(DW);
   localparam logic [DW-1:0] MID   = MID64[DW-1:0];

   initial assert (DW >= 2 && DW <= 64) else $error("dacbus_daclatch: DW out of range");

   logic [DW-1:0] clr_val;
   assign clr_val = rd_wrn ? MID : '0;

   // clear outranks load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_q <= '0;
      end else if (!clear_n) begin
         dac_q <= clr_val;
      end else if (!load_n) begin
         dac_q <= src;
      end
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_n && !rd_wrn) |=> (dac_q == '0)); // R7
   AST_CLEAR_MID: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_n && rd_wrn) |=> (dac_q == MID)); // R7
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_n && !load_n) |=> ($countones(dac_q) <= 1)); // R9
   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_n && !load_n) |=> (dac_q == $past(src))); // R5
   AST_LATCH_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_n && load_n) |=> $stable(dac_q)); // R5

endmodule

// File: rtl/dacbus_holdtimer.sv
`timescale 1ns/1ps
module dacbus_holdtimer #(
   parameter int HOLD_CYCLES = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_n,
   output logic hold
);

   localparam int CW = $clog2(HOLD_CYCLES + 1);
   localparam logic [CW-1:0] START = CW'(HOLD_CYCLES);

   initial assert (HOLD_CYCLES >= 1) else $error("dacbus_holdtimer: HOLD_CYCLES must be positive");

   logic          load_prev;
   logic          fall;
   logic [CW-1:0] cnt;

   assign fall = load_prev && !load_n;
   assign hold = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_prev <= 1'b1;
         cnt       <= '0;
      end else begin
         load_prev <= load_n;
         if (fall) begin
            cnt <= START;
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // length of the current hold run, counted independently of cnt
   logic [CW:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
      end else if (fall) begin
         run_len <= (CW+1)'(1);
      end else if (hold) begin
         run_len <= run_len + 1'b1;
      end else begin
         run_len <= '0;
      end
   end

   AST_HOLD_START: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> hold); // R10
   AST_HOLD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall && !hold) |=> !hold); // R10
   AST_HOLD_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (run_len <= (CW+1)'(HOLD_CYCLES))); // R10
   AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && hold) |=> hold); // R11

endmodule

// File: rtl/dacbus_ctl.sv
`timescale 1ns/1ps
module dacbus_ctl
   import dacbus_pkg::*;
#(
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 500
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          rd_wrn,
   input  logic          load_n,
   input  logic          clear_n,
   input  logic [DW-1:0] bus_in,
   output logic [DW-1:0] bus_out,
   output logic          bus_oe,
   output logic [DW-1:0] dac_code,
   output logic          hold
);

   localparam int SW = CTL_W + DW;
   localparam logic [SW-1:0] SAMP_RST = {CTL_IDLE, {DW{1'b0}}};

   initial assert (DW >= 2 && DW <= 64) else $error("dacbus_ctl: DW out of range");

   ctl_t          ctl_raw;
   ctl_t          ctl_s;
   logic [DW-1:0] data_s;
   logic [SW-1:0] samp_out;
   logic [DW-1:0] in_word;

   assign ctl_raw = '{sel_n: sel_n, rd_wrn: rd_wrn, load_n: load_n, clear_n: clear_n};

   // control and data share one chain so they stay aligned (R12)
   dacbus_sampler #(
      .W      (SW),
      .STAGES (SYNC_STAGES),
      .RST    (SAMP_RST)
   ) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({ctl_raw, bus_in}),
      .dout  (samp_out)
   );

   assign {ctl_s, data_s} = samp_out;

   dacbus_inlatch #(
      .DW (DW)
   ) u_inlatch (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n   (ctl_s.sel_n),
      .rd_wrn  (ctl_s.rd_wrn),
      .din     (data_s),
      .latch_q (in_word),
      .bus_out (bus_out),
      .bus_oe  (bus_oe)
   );

   dacbus_daclatch #(
      .DW (DW)
   ) u_daclatch (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_wrn  (ctl_s.rd_wrn),
      .load_n  (ctl_s.load_n),
      .clear_n (ctl_s.clear_n),
      .src     (in_word),
      .dac_q   (dac_code)
   );

   dacbus_holdtimer #(
      .HOLD_CYCLES (HOLD_CYCLES)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_n (ctl_s.load_n),
      .hold   (hold)
   );

   AST_CLEAR_KEEPS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_s.clear_n && ctl_s.sel_n) |=> $stable(in_word)); // R8
   AST_OE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> $past(!ctl_s.sel_n && ctl_s.rd_wrn)); // R4

endmodule

// File: tb/dacbus_ctl_tb_top.sv
`timescale 1ns/1ps
module dacbus_ctl_tb_top;

   localparam int DW   = 16;
   localparam int SYNC = 2;
   localparam int HOLD = 500;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_n = 1'b1;
   logic          rd_wrn = 1'b1;
   logic          load_n = 1'b1;
   logic          clear_n = 1'b1;
   logic [DW-1:0] bus_in = '0;
   logic [DW-1:0] bus_out;
   logic          bus_oe;
   logic [DW-1:0] dac_code;
   logic          hold;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   dacbus_ctl #(
      .DW          (DW),
      .SYNC_STAGES (SYNC),
      .HOLD_CYCLES (HOLD)
   ) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_n    (sel_n),
      .rd_wrn   (rd_wrn),
      .load_n   (load_n),
      .clear_n  (clear_n),
      .bus_in   (bus_in),
      .bus_out  (bus_out),
      .bus_oe   (bus_oe),
      .dac_code (dac_code),
      .hold     (hold)
   );

   typedef struct packed {
      logic [7:0]  req;
      logic        cs_n;
      logic        rw;
      logic        ld_n;
      logic        clr_n;
      logic [15:0] data;
      logic [15:0] exp_dac;
      logic        exp_oe;
      logic [15:0] exp_bus;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      '{8'd2, 1'b1,1'b0,1'b1,1'b1, 16'hAAAA, 16'h0000, 1'b0, 16'h0000}, // R2 idle, no drive
      '{8'd3, 1'b0,1'b0,1'b1,1'b1, 16'h1234, 16'h0000, 1'b0, 16'h0000}, // R3 write
      '{8'd4, 1'b0,1'b1,1'b1,1'b1, 16'h0000, 16'h0000, 1'b1, 16'h1234}, // R4 readback
      '{8'd5, 1'b1,1'b0,1'b0,1'b1, 16'hFFFF, 16'h1234, 1'b0, 16'h0000}, // R5 load, cs high
      '{8'd5, 1'b1,1'b0,1'b1,1'b1, 16'hFFFF, 16'h1234, 1'b0, 16'h0000}, // R5 load released
      '{8'd2, 1'b0,1'b1,1'b1,1'b1, 16'h0000, 16'h1234, 1'b1, 16'h1234}, // R2 cs-high word ignored
      '{8'd5, 1'b0,1'b0,1'b1,1'b1, 16'hBEEF, 16'h1234, 1'b0, 16'h0000}, // R5 write, DAC steady
      '{8'd4, 1'b0,1'b1,1'b1,1'b1, 16'h0000, 16'h1234, 1'b1, 16'hBEEF}, // R4
      '{8'd7, 1'b1,1'b0,1'b1,1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000}, // R7 clear to zero
      '{8'd8, 1'b0,1'b1,1'b1,1'b1, 16'h0000, 16'h0000, 1'b1, 16'hBEEF}, // R8 input kept
      '{8'd7, 1'b1,1'b1,1'b1,1'b0, 16'h0000, 16'h8000, 1'b0, 16'h0000}, // R7 clear to midscale
      '{8'd9, 1'b1,1'b1,1'b0,1'b0, 16'h0000, 16'h8000, 1'b0, 16'h0000}, // R9 clear over load
      '{8'd5, 1'b1,1'b1,1'b0,1'b1, 16'h0000, 16'hBEEF, 1'b0, 16'h0000}, // R5 load after clear
      '{8'd6, 1'b0,1'b0,1'b0,1'b1, 16'h0F0F, 16'h0F0F, 1'b0, 16'h0000}, // R6 follow
      '{8'd6, 1'b0,1'b0,1'b0,1'b1, 16'h7FFF, 16'h7FFF, 1'b0, 16'h0000}, // R6 follow
      '{8'd4, 1'b0,1'b1,1'b0,1'b1, 16'h0000, 16'h7FFF, 1'b1, 16'h7FFF}, // R4
      '{8'd2, 1'b1,1'b1,1'b1,1'b1, 16'h0000, 16'h7FFF, 1'b0, 16'h0000}, // R2 released
      '{8'd9, 1'b0,1'b0,1'b0,1'b0, 16'h5555, 16'h0000, 1'b0, 16'h0000}, // R9 clear over load
      '{8'd8, 1'b0,1'b1,1'b1,1'b1, 16'h0000, 16'h0000, 1'b1, 16'h5555}  // R8 write kept
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic cs, input logic rw, input logic ld,
                        input logic clr, input logic [DW-1:0] d);
      @(negedge clk);
      sel_n = cs; rd_wrn = rw; load_n = ld; clear_n = clr; bus_in = d;
   endtask

   task automatic settle();
      repeat (SYNC + 2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #4000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int cnt;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1 reset state
      check("R1 oe", {31'b0, bus_oe}, 32'd0);
      check("R1 dac", {16'b0, dac_code}, 32'h0);
      check("R1 hold", {31'b0, hold}, 32'd0);
      drive(1'b0, 1'b1, 1'b1, 1'b1, 16'h0000);
      settle();
      check("R1 readback", {15'b0, bus_oe, bus_out}, {15'b0, 1'b1, 16'h0000});

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].cs_n, TBL[i].rw, TBL[i].ld_n, TBL[i].clr_n, TBL[i].data);
         settle();
         check($sformatf("R%0d vec%0d dac", TBL[i].req, i), {16'b0, dac_code}, {16'b0, TBL[i].exp_dac});
         check($sformatf("R%0d vec%0d oe", TBL[i].req, i), {31'b0, bus_oe}, {31'b0, TBL[i].exp_oe});
         if (TBL[i].exp_oe)
            check($sformatf("R%0d vec%0d bus", TBL[i].req, i), {16'b0, bus_out}, {16'b0, TBL[i].exp_bus});
      end

      // state: input latch 5555, DAC 0000, load high; let any hold expire
      drive(1'b1, 1'b1, 1'b1, 1'b1, 16'h0000);
      repeat (HOLD + 10) @(posedge clk);

      // R12 exact latency, R10 single-edge hold length
      @(negedge clk);
      load_n = 1'b0;
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      check("R12 dac before", {16'b0, dac_code}, 32'h0);
      check("R12 hold before", {31'b0, hold}, 32'd0);
      @(negedge clk);
      check("R12 dac after", {16'b0, dac_code}, 32'h5555);
      check("R12 hold after", {31'b0, hold}, 32'd1);
      cnt = hold ? 1 : 0;
      for (int k = 0; k < 2 * HOLD; k++) begin
         @(negedge clk);
         if (hold) cnt++;
      end
      check("R10 hold length", cnt, HOLD);
      check("R10 no hold on steady low", {31'b0, hold}, 32'd0);

      // R11 retrigger during hold
      @(negedge clk);
      load_n = 1'b1;
      repeat (10) @(negedge clk);
      load_n = 1'b0;
      cnt = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (hold) cnt++;
      end
      load_n = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (hold) cnt++;
      end
      load_n = 1'b0;
      for (int k = 0; k < 2 * HOLD; k++) begin
         @(negedge clk);
         if (hold) cnt++;
      end
      check("R11 retriggered hold length", cnt, HOLD + 105);
      check("R11 hold ends", {31'b0, hold}, 32'd0);

      finish_run();
   end

endmodule